// File: doc/BRIEF.md
# ADPCM Command Stream Parser

This block reads an 8-bit command stream and turns it into what an ADPCM decoder needs: a stream of 4-bit data nibbles, a 5-bit sample-rate code, timed silence requests, and an end-of-sample indication. Command bytes arrive on a valid/ready port. They may come from a ROM fetcher (master mode) or from a host writing the port directly (slave mode). Nibbles leave on a second valid/ready port. The block also holds the sample-rate divider. That divider counts qualified ticks of a 640 kHz base clock and pulses once per decoder sample.

A burst opcode carries its own rate code. The burst length is either fixed at 256 nibbles or given by a following length byte. When a burst has an odd nibble count, its last nibble is thrown away, so the next command always starts on a byte boundary.

Silence opcodes hold off the input for a number of milliseconds. Each millisecond lasts a programmable number of clock cycles.

In slave mode the engine sleeps after reset. The first byte written only wakes it, and a terminating opcode puts it back to sleep.

Top module: `adpcm_cmd_parser`

## Requirements
- R1: After reset, `nib_valid`, `sil_active`, `end_pulse` and `unk_pulse` are 0, `rate_code` is 0 and `in_ready` is 1. `engine_on` is 1 in master mode and 0 in slave mode.
- R2: In slave mode, while `engine_on` is 0, an accepted byte only raises `engine_on`. Its value produces no nibble, no silence and no change of `rate_code`.
- R3: A command byte of the form 01xrrrrr sets `rate_code` to rrrrr and is followed by 128 data bytes that yield exactly 256 nibbles.
- R4: A command byte of the form 10xrrrrr sets `rate_code` to rrrrr. The next byte N is a length, and N+1 nibbles follow.
- R5: In a burst with an odd nibble count, the low nibble of the final byte is never emitted, and the next byte is decoded as a command.
- R6: Each data byte is emitted as two nibbles, bits 7:4 first and bits 3:0 second.
- R7: A command byte 0x01 to 0x3F sets `sil_ms` to its low 6 bits and holds `sil_active` high for exactly `sil_ms` × `ticks_per_ms` cycles. Throughout that time `in_ready` is 0.
- R8: A byte 0x00 or 0xFF seen while no command other than 0x00/0xFF has been decoded since reset or since the last end gives no `end_pulse`.
- R9: Otherwise, a command byte 0x00 or 0xFF pulses `end_pulse` for one cycle and clears the started condition. In slave mode it also drops `engine_on`.
- R10: A command byte 11xxxxxx other than 0xFF pulses `unk_pulse` for one cycle. It changes neither `rate_code`, the nibble output nor the silence state.
- R11: With `base_tick` high, `sample_tick` pulses once every 4 × (`rate_code` + 1) base ticks.
- R12: While `nib_valid` is 1 and `nib_ready` is 0, `nib_data` holds steady and `in_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slave_mode | input | 1 | 1 selects host-fed slave mode, sampled at reset |
| base_tick | input | 1 | One-cycle qualifier of the 640 kHz base clock |
| ticks_per_ms | input | 16 | Clock cycles per silence millisecond (0 treated as 1) |
| in_valid | input | 1 | Command byte valid |
| in_data | input | 8 | Command or data byte |
| in_ready | output | 1 | Parser accepts a byte |
| nib_valid | output | 1 | Nibble valid |
| nib_data | output | 4 | ADPCM data nibble |
| nib_ready | input | 1 | Decoder accepts the nibble |
| rate_code | output | 5 | Rate code of the latest burst opcode |
| sample_tick | output | 1 | One-cycle decoder sample strobe |
| sil_active | output | 1 | Silence interval in progress |
| sil_ms | output | 6 | Duration of the latest silence request in ms |
| end_pulse | output | 1 | One-cycle end/stop indication |
| unk_pulse | output | 1 | One-cycle unknown-opcode flag |
| engine_on | output | 1 | Engine awake |

## Verification
The rate divider keeps counting on every base tick. A new burst opcode can therefore rewrite `rate_code` in the same cycle that the divider advances. This matters most when the new code is smaller than the divider's current count. The bench holds `base_tick` high for the whole run, so the six table bursts change the rate at arbitrary divider phases. After the last change it waits for any `sample_tick` and measures the following interval. That interval must equal four times the new code plus one, with no stray or missing pulse.

// File: rtl/adpcm_cmd_pkg.sv
// Package: shared widths, parser states and opcode classes for the
// ADPCM command stream parser. Assumes 8-bit command bytes.
package adpcm_cmd_pkg;

    localparam int BYTE_W = 8;
    localparam int NIB_W  = 4;
    localparam int RATE_W = 5;
    localparam int SIL_W  = 6;

    typedef enum logic [1:0] {
        PS_SLEEP = 2'd0,   // slave mode, waiting for wake-up write
        PS_CMD   = 2'd1,   // decoding commands / feeding burst bytes
        PS_LEN   = 2'd2    // waiting for the length byte of a variable burst
    } parse_state_t;

    typedef enum logic [2:0] {
        OK_END,
        OK_STOP,
        OK_SIL,
        OK_FULL,
        OK_VAR,
        OK_UNK
    } op_kind_t;

    // Sorts a command byte into its opcode class.
    function automatic op_kind_t classify(input logic [BYTE_W-1:0] b);
        op_kind_t k;
        if (b == 8'h00)      k = OK_END;
        else if (b == 8'hFF) k = OK_STOP;
        else begin
            case (b[7:6])
                2'b00:   k = OK_SIL;
                2'b01:   k = OK_FULL;
                2'b10:   k = OK_VAR;
                default: k = OK_UNK;
            endcase
        end
        return k;
    endfunction

endpackage

// File: rtl/acp_rate_div.sv
// Sample-rate divider. It prescales the base-clock qualifier by PRE_DIV,
// then divides by (rate_code+1) and emits a one-cycle sample strobe.
// Assumes base_tick is a single-cycle enable in the clk domain. A rate
// code lowered mid-count is absorbed by the >= comparison.
module acp_rate_div #(
    parameter int RATE_W  = 5,
    parameter int PRE_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_tick,
    input  logic [RATE_W-1:0] rate_code,
    output logic              sample_tick
);
    localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);

    logic [PRE_W-1:0]  pre_q;
    logic [RATE_W-1:0] div_q;

    // Advance prescaler and divider on each base tick, strobe on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q       <= '0;
            div_q       <= '0;
            sample_tick <= 1'b0;
        end else begin
            sample_tick <= 1'b0;
            if (base_tick) begin
                if (pre_q == PRE_LAST) begin
                    pre_q <= '0;
                    if (div_q >= rate_code) begin
                        div_q       <= '0;
                        sample_tick <= 1'b1;
                    end else begin
                        div_q <= div_q + 1'b1;
                    end
                end else begin
                    pre_q <= pre_q + 1'b1;
                end
            end
        end
    end

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        sample_tick |=> !sample_tick); // R11

endmodule

// File: rtl/acp_silence_timer.sv
// Silence timer. On start it latches a millisecond count and stays busy
// for count * ticks_per_ms cycles. Assumes start is raised only when not
// busy and with a nonzero count. A ticks_per_ms of 0 acts as 1.
module acp_silence_timer #(
    parameter int SIL_W = 6,
    parameter int TPM_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [SIL_W-1:0] dur,
    input  logic [TPM_W-1:0] ticks_per_ms,
    output logic             busy,
    output logic [SIL_W-1:0] dur_q
);
    logic [SIL_W-1:0] ms_left_q;
    logic [TPM_W-1:0] tick_q;
    logic [TPM_W-1:0] tick_last;

    // Last tick index of one millisecond, guarding a zero setting.
    always_comb tick_last = (ticks_per_ms == '0) ? '0 : ticks_per_ms - 1'b1;

    // Count ticks within a millisecond and milliseconds within the interval.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            ms_left_q <= '0;
            tick_q    <= '0;
            dur_q     <= '0;
        end else if (start) begin
            busy      <= 1'b1;
            ms_left_q <= dur;
            tick_q    <= '0;
            dur_q     <= dur;
        end else if (busy) begin
            if (tick_q >= tick_last) begin
                tick_q    <= '0;
                ms_left_q <= ms_left_q - 1'b1;
                if (ms_left_q == SIL_W'(1)) busy <= 1'b0;
            end else begin
                tick_q <= tick_q + 1'b1;
            end
        end
    end

    AST_SIL_DUR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(dur_q)); // R7

    AST_SIL_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ms_left_q != '0); // R7

endmodule

// File: rtl/acp_nibble_out.sv
// Nibble emitter. It is armed with a nibble count, takes one data byte
// at a time, and hands out the high nibble and then the low nibble on a
// valid/ready port. When the count runs out after a high nibble, the low
// nibble of that byte is dropped.
module acp_nibble_out #(
    parameter int NIB_W = 4,
    parameter int CNT_W = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               arm,
    input  logic [CNT_W-1:0]   arm_count,
    input  logic               byte_load,
    input  logic [2*NIB_W-1:0] byte_in,
    output logic               burst_active,
    output logic               need_byte,
    output logic               nib_valid,
    output logic [NIB_W-1:0]   nib_data,
    input  logic               nib_ready
);
    logic [CNT_W-1:0]   rem_q;
    logic [2*NIB_W-1:0] hold_q;
    logic               full_q;
    logic               low_q;
    logic               nib_fire;

    // Status toward the command decoder and the nibble port.
    always_comb begin
        burst_active = (rem_q != '0);
        need_byte    = burst_active && !full_q;
        nib_valid    = full_q;
        nib_data     = low_q ? hold_q[NIB_W-1:0] : hold_q[2*NIB_W-1:NIB_W];
        nib_fire     = full_q && nib_ready;
    end

    // Track remaining nibbles, the held byte and which half goes out next.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            hold_q <= '0;
            full_q <= 1'b0;
            low_q  <= 1'b0;
        end else begin
            if (arm) rem_q <= arm_count;
            if (byte_load) begin
                hold_q <= byte_in;
                full_q <= 1'b1;
                low_q  <= 1'b0;
            end else if (nib_fire) begin
                rem_q <= rem_q - 1'b1;
                if (!low_q && rem_q != CNT_W'(1)) begin
                    low_q <= 1'b1;
                end else begin
                    full_q <= 1'b0;
                    low_q  <= 1'b0;
                end
            end
        end
    end

    AST_NIB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        nib_valid && !nib_ready |=> nib_valid && $stable(nib_data)); // R12

    AST_NO_LOAD_WHILE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        byte_load |-> !full_q && burst_active); // R12

    AST_NO_ORPHAN_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        nib_valid |-> burst_active); // R5

endmodule

// File: rtl/acp_cmd_fsm.sv
// Command decoder. It accepts bytes from the input port, sorts them into
// opcodes, and drives the nibble emitter, the silence timer and the rate
// register. It tracks whether real data has been seen, which decides
// whether 0x00/0xFF terminate. Assumes slave_mode is steady while out of
// reset.
module acp_cmd_fsm
    import adpcm_cmd_pkg::*;
#(
    parameter int CNT_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slave_mode,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    output logic              in_ready,
    input  logic              burst_active,
    input  logic              need_byte,
    input  logic              sil_busy,
    output logic              arm,
    output logic [CNT_W-1:0]  arm_count,
    output logic              byte_load,
    output logic              sil_start,
    output logic [SIL_W-1:0]  sil_dur,
    output logic [RATE_W-1:0] rate_code,
    output logic              end_pulse,
    output logic              unk_pulse,
    output logic              engine_on
);
    localparam logic [CNT_W-1:0] FULL_BURST = CNT_W'(256);

    parse_state_t state_q;
    logic         started_q;
    logic         accept;
    logic         cmd_take;
    op_kind_t     kind;

    // Readiness per state, the handshake, and the decode of the current byte.
    always_comb begin
        case (state_q)
            PS_CMD:  in_ready = burst_active ? need_byte : !sil_busy;
            default: in_ready = 1'b1;
        endcase
        accept    = in_valid && in_ready;
        kind      = classify(in_data);
        cmd_take  = accept && (state_q == PS_CMD) && !burst_active;
        byte_load = accept && (state_q == PS_CMD) && burst_active;
        sil_start = cmd_take && (kind == OK_SIL);
        sil_dur   = in_data[SIL_W-1:0];
        arm       = (cmd_take && kind == OK_FULL) || (accept && state_q == PS_LEN);
        arm_count = (state_q == PS_LEN) ? CNT_W'(in_data) + 1'b1 : FULL_BURST;
        engine_on = (state_q != PS_SLEEP);
    end

    // Update state, started flag, rate code and the one-cycle flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= slave_mode ? PS_SLEEP : PS_CMD;
            started_q <= 1'b0;
            rate_code <= '0;
            end_pulse <= 1'b0;
            unk_pulse <= 1'b0;
        end else begin
            end_pulse <= 1'b0;
            unk_pulse <= 1'b0;
            if (accept && state_q == PS_SLEEP) begin
                state_q <= PS_CMD;
            end else if (accept && state_q == PS_LEN) begin
                state_q <= PS_CMD;
            end else if (cmd_take) begin
                case (kind)
                    OK_END, OK_STOP: begin
                        if (started_q) begin
                            end_pulse <= 1'b1;
                            started_q <= 1'b0;
                            if (slave_mode) state_q <= PS_SLEEP;
                        end
                    end
                    OK_FULL: begin
                        rate_code <= in_data[RATE_W-1:0];
                        started_q <= 1'b1;
                    end
                    OK_VAR: begin
                        rate_code <= in_data[RATE_W-1:0];
                        started_q <= 1'b1;
                        state_q   <= PS_LEN;
                    end
                    OK_UNK: begin
                        unk_pulse <= 1'b1;
                        started_q <= 1'b1;
                    end
                    default: started_q <= 1'b1;
                endcase
            end
        end
    end

    AST_SIL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        sil_busy |-> !in_ready); // R7

    AST_UNK_RATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        unk_pulse |-> $stable(rate_code)); // R10

    AST_SLEEP_NO_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        !engine_on |-> !burst_active && !sil_busy); // R2

    AST_END_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        end_pulse |=> !end_pulse); // R9

endmodule

// File: rtl/adpcm_cmd_parser.sv
// Top of the ADPCM command stream parser. It connects the command
// decoder, the nibble emitter, the silence timer and the sample-rate
// divider. Assumes a single clock, with the 640 kHz base clock presented
// as a one-cycle qualifier.
module adpcm_cmd_parser
    import adpcm_cmd_pkg::*;
#(
    parameter int TPM_W   = 16,
    parameter int PRE_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slave_mode,
    input  logic              base_tick,
    input  logic [TPM_W-1:0]  ticks_per_ms,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    output logic              in_ready,
    output logic              nib_valid,
    output logic [NIB_W-1:0]  nib_data,
    input  logic              nib_ready,
    output logic [RATE_W-1:0] rate_code,
    output logic              sample_tick,
    output logic              sil_active,
    output logic [SIL_W-1:0]  sil_ms,
    output logic              end_pulse,
    output logic              unk_pulse,
    output logic              engine_on
);
    localparam int CNT_W = BYTE_W + 1;

    logic             burst_active;
    logic             need_byte;
    logic             arm;
    logic [CNT_W-1:0] arm_count;
    logic             byte_load;
    logic             sil_start;
    logic [SIL_W-1:0] sil_dur;

    acp_cmd_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .slave_mode   (slave_mode),
        .in_valid     (in_valid),
        .in_data      (in_data),
        .in_ready     (in_ready),
        .burst_active (burst_active),
        .need_byte    (need_byte),
        .sil_busy     (sil_active),
        .arm          (arm),
        .arm_count    (arm_count),
        .byte_load    (byte_load),
        .sil_start    (sil_start),
        .sil_dur      (sil_dur),
        .rate_code    (rate_code),
        .end_pulse    (end_pulse),
        .unk_pulse    (unk_pulse),
        .engine_on    (engine_on)
    );

    acp_nibble_out #(.NIB_W(NIB_W), .CNT_W(CNT_W)) u_nib (
        .clk          (clk),
        .rst_n        (rst_n),
        .arm          (arm),
        .arm_count    (arm_count),
        .byte_load    (byte_load),
        .byte_in      (in_data),
        .burst_active (burst_active),
        .need_byte    (need_byte),
        .nib_valid    (nib_valid),
        .nib_data     (nib_data),
        .nib_ready    (nib_ready)
    );

    acp_silence_timer #(.SIL_W(SIL_W), .TPM_W(TPM_W)) u_sil (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (sil_start),
        .dur          (sil_dur),
        .ticks_per_ms (ticks_per_ms),
        .busy         (sil_active),
        .dur_q        (sil_ms)
    );

    acp_rate_div #(.RATE_W(RATE_W), .PRE_DIV(PRE_DIV)) u_div (
        .clk          (clk),
        .rst_n        (rst_n),
        .base_tick    (base_tick),
        .rate_code    (rate_code),
        .sample_tick  (sample_tick)
    );

    AST_SIL_NO_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        sil_active |-> !nib_valid); // R7

endmodule

// File: tb/tb_adpcm_cmd_parser.sv
module tb_adpcm_cmd_parser;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slave_mode = 1'b0;
    logic        base_tick = 1'b1;
    logic [15:0] ticks_per_ms = 16'd3;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_ready;
    logic        nib_valid;
    logic [3:0]  nib_data;
    logic        nib_ready = 1'b1;
    logic [4:0]  rate_code;
    logic        sample_tick;
    logic        sil_active;
    logic [5:0]  sil_ms;
    logic        end_pulse;
    logic        unk_pulse;
    logic        engine_on;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    adpcm_cmd_parser dut (
        .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode), .base_tick(base_tick),
        .ticks_per_ms(ticks_per_ms), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .nib_valid(nib_valid), .nib_data(nib_data),
        .nib_ready(nib_ready), .rate_code(rate_code), .sample_tick(sample_tick),
        .sil_active(sil_active), .sil_ms(sil_ms), .end_pulse(end_pulse),
        .unk_pulse(unk_pulse), .engine_on(engine_on)
    );

    // Burst vectors: {opcode, length byte, expected nibbles, expected rate}.
    localparam int NV = 6;
    localparam logic [39:0] VEC [NV] = '{
        {8'h45, 8'h00, 16'd256, 8'd5},
        {8'h83, 8'h04, 16'd5,   8'd3},
        {8'h9F, 8'h00, 16'd1,   8'd31},
        {8'h61, 8'h00, 16'd256, 8'd1},
        {8'h80, 8'h07, 16'd8,   8'd0},
        {8'h82, 8'h02, 16'd3,   8'd2}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic mode);
        @(negedge clk);
        rst_n = 1'b0;
        slave_mode = mode;
        in_valid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Drive one byte and return just after the edge that accepts it.
    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    function automatic logic [7:0] pat(input int v, input int k);
        return 8'((k * 37) + 8'h5A + (v * 11));
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int n;
        // ---------------- master mode ----------------
        do_reset(1'b0);
        chk(in_ready == 1'b1,  "R1 in_ready",  in_ready, 1);
        chk(nib_valid == 1'b0, "R1 nib_valid", nib_valid, 0);
        chk(sil_active == 1'b0, "R1 sil_active", sil_active, 0);
        chk(end_pulse == 1'b0 && unk_pulse == 1'b0, "R1 pulses", end_pulse, 0);
        chk(rate_code == 5'd0, "R1 rate_code", rate_code, 0);
        chk(engine_on == 1'b1, "R1 engine_on master", engine_on, 1);

        send_byte(8'h00);
        chk(end_pulse == 1'b0, "R8 early 00", end_pulse, 0);
        send_byte(8'hFF);
        chk(end_pulse == 1'b0, "R8 early FF", end_pulse, 0);

        // Table walk: bursts R3/R4/R6, each followed by a command probe (R5, R10).
        for (int v = 0; v < NV; v++) begin
            logic [7:0] op;
            logic [7:0] ln;
            int cnt;
            int rte;
            logic [4:0] rate_before;
            op  = VEC[v][39:32];
            ln  = VEC[v][31:24];
            cnt = int'(VEC[v][23:8]);
            rte = int'(VEC[v][7:0]);
            fork
                begin
                    send_byte(op);
                    if (op[7]) send_byte(ln);
                    for (int k = 0; k < (cnt + 1) / 2; k++) send_byte(pat(v, k));
                end
                begin
                    int got;
                    got = 0;
                    while (got < cnt) begin
                        @(negedge clk);
                        if (nib_valid) begin
                            logic [7:0] b;
                            logic [3:0] e;
                            b = pat(v, got / 2);
                            e = (got % 2 == 0) ? b[7:4] : b[3:0];
                            chk(nib_data == e, "R6 nibble order", nib_data, e);
                            got++;
                        end
                    end
                end
            join
            @(negedge clk);
            chk(rate_code == 5'(rte), op[7] ? "R4 rate" : "R3 rate", rate_code, rte);
            chk(nib_valid == 1'b0, "R5 no extra nibble", nib_valid, 0);
            rate_before = rate_code;
            send_byte(8'hC5);
            chk(unk_pulse == 1'b1, "R5 next byte is command", unk_pulse, 1);
            chk(rate_code == rate_before, "R10 rate kept", rate_code, rate_before);
            @(negedge clk);
            chk(nib_valid == 1'b0 && sil_active == 1'b0, "R10 no effect", nib_valid, 0);
        end

        // R11: interval after the last rate change (code 2 -> 12 base ticks).
        @(negedge clk);
        while (!sample_tick) @(negedge clk);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!sample_tick);
        chk(n == 12, "R11 tick interval", n, 12);

        send_byte(8'h00);
        chk(end_pulse == 1'b1, "R9 master end", end_pulse, 1);
        chk(engine_on == 1'b1, "R9 master stays on", engine_on, 1);
        send_byte(8'h00);
        chk(end_pulse == 1'b0, "R8 after end", end_pulse, 0);

        // R7: silence of 5 ms at 3 cycles per ms.
        send_byte(8'h05);
        chk(sil_ms == 6'd5, "R7 sil_ms", sil_ms, 5);
        n = 0;
        @(negedge clk);
        while (sil_active) begin
            if (in_ready) chk(1'b0, "R7 in_ready during silence", 1, 0);
            n++;
            @(negedge clk);
        end
        chk(n == 15, "R7 silence length", n, 15);
        chk(in_ready == 1'b1, "R7 ready after silence", in_ready, 1);

        // ---------------- slave mode ----------------
        do_reset(1'b1);
        chk(engine_on == 1'b0, "R1 engine_on slave", engine_on, 0);
        send_byte(8'h42);
        chk(engine_on == 1'b1, "R2 wake", engine_on, 1);
        chk(rate_code == 5'd0, "R2 value ignored", rate_code, 0);
        repeat (3) begin
            @(negedge clk);
            chk(nib_valid == 1'b0 && sil_active == 1'b0, "R2 quiet", nib_valid, 0);
        end
        send_byte(8'hFF);
        chk(end_pulse == 1'b0, "R8 slave FF start", end_pulse, 0);
        send_byte(8'h00);
        chk(end_pulse == 1'b0, "R8 slave 00", end_pulse, 0);

        nib_ready = 1'b0;
        send_byte(8'h81);
        send_byte(8'h00);
        send_byte(8'hA7);
        @(negedge clk);
        chk(nib_valid == 1'b1 && nib_data == 4'hA, "R12 held nibble", nib_data, 10);
        chk(in_ready == 1'b0, "R12 in_ready low", in_ready, 0);
        repeat (3) begin
            @(negedge clk);
            chk(nib_valid == 1'b1 && nib_data == 4'hA, "R12 stable", nib_data, 10);
        end
        nib_ready = 1'b1;
        @(negedge clk);
        chk(nib_valid == 1'b0, "R5 odd low nibble dropped", nib_valid, 0);
        send_byte(8'hFF);
        chk(end_pulse == 1'b1, "R9 slave stop", end_pulse, 1);
        chk(engine_on == 1'b0, "R9 slave sleeps", engine_on, 0);
        send_byte(8'h05);
        chk(engine_on == 1'b1, "R2 rewake", engine_on, 1);
        @(negedge clk);
        chk(sil_active == 1'b0, "R2 no silence on wake byte", sil_active, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule